// File: doc/BRIEF.md
# Event Prescaler and Pulse Counter

This block counts rising edges on one of several asynchronous event inputs, including inputs that toggle faster than the bus clock. A 6-bit source field picks which input is counted. The count runs in the event's own clock domain, driven by the selected input itself. Software reads the count through a capture register. Any write to that register takes a snapshot of the live count into a bus-domain holding register, and a read returns that snapshot.

The block also produces a divided-down output event. This output can serve as a start or stop source for a time-to-digital converter. A single ratio bit chooses whether the output toggles every 16th or every 64th counted edge.

An active-low run bit in the control register keeps the prescaler in reset. While it is held, the count rests at 2 and the output event is low. Counting begins from that state when the bit is set. The first three edges after release leave the count at 2, and each later edge adds one. A snapshot therefore reads the number of pulses minus one, with a floor of 2. The live count is carried into the bus domain as a Gray code through a two-stage synchronizer. As a result a snapshot is stable whenever the input has been quiet for a couple of bus cycles.

Top module: `evt_prescaler`

## Requirements
- R1: After system reset, ctl_rdata reads 0x3F (bit 7 run = 0, bit 6 ratio = 0, bits 5:0 source = 63), cap_rdata reads 0 and pre_evt is 0.
- R2: While control bit 7 is 0, the counter rests at 2 and pre_evt is 0, and input edges have no effect. Clearing bit 7 forces pre_evt low by the next bus clock edge.
- R3: After bit 7 is set, a snapshot reads 2 if fewer than 3 rising edges have arrived on the selected input. Otherwise it reads the number of rising edges minus one.
- R4: Each rising edge past the third adds one to the counter, modulo 2^16, with no saturation.
- R5: Any write to the capture register (cap_we high for one cycle) loads the live count into cap_rdata on the next bus clock edge. With no write, cap_rdata holds its value.
- R6: With ratio 0, pre_evt starts low at release and toggles on every 16th rising edge counted since release.
- R7: With ratio 1, pre_evt toggles on every 64th rising edge counted since release.
- R8: Source value s selects src_vec[s]. A source value of NUM_SRC or above selects no input, and the count stays at 2.
- R9: A control write updates bits 5:0 only if bit 7 was 0 before the write. Bits 7 and 6 are written on every control write.
- R10: Input pulses shorter than a bus clock period (1 ns high, 1 ns low against a 4 ns bus clock) are each counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| src_vec | input | NUM_SRC | Asynchronous event inputs |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit 7 run, bit 6 ratio, bits 5:0 source |
| ctl_rdata | output | 8 | Control register readback |
| cap_we | input | 1 | Capture register write strobe (data ignored) |
| cap_rdata | output | 16 | Captured count |
| pre_evt | output | 1 | Prescaled output event |

## Verification
A wrong edge pre-count or a wrong reset value in the event counter shows up in the first snapshot taken after a short burst. Such a snapshot reads 2 for zero to three pulses and pulses minus one after that. A snapshot taken one bus cycle after the write exposes a lost or doubled increment, a wrong Gray conversion, or a stuck synchronizer. A divider fault shows as the wrong pre_evt level at the 16th or 64th edge. A broken source lock shows immediately in ctl_rdata after a write made while running. A wrap fault appears only after 65536 edges, so a long burst of fast pulses drives the counter through wrap-around.

// File: rtl/evt_prescaler_pkg.sv
package evt_prescaler_pkg;

    localparam int EP_SEL_W     = 6;
    localparam int EP_CNT_W     = 16;
    localparam int EP_DIV_W     = 6;
    localparam int EP_FAST_LOG2 = 4;
    localparam int EP_CNT_RST   = 2;
    localparam int EP_CTL_W     = EP_SEL_W + 2;

    typedef struct packed {
        logic                run;
        logic                ratio;
        logic [EP_SEL_W-1:0] sel;
    } ep_ctl_t;

endpackage

// File: rtl/ep_ctl_reg.sv
module ep_ctl_reg
    import evt_prescaler_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [EP_CTL_W-1:0] wdata,
    output ep_ctl_t             ctl_o
);

    ep_ctl_t ctl_d, ctl_q;
    ep_ctl_t wr;

    always_comb begin
        wr    = ep_ctl_t'(wdata);
        ctl_d = ctl_q;
        if (we) begin
            ctl_d.run   = wr.run;
            ctl_d.ratio = wr.ratio;
            if (!ctl_q.run) begin
                ctl_d.sel = wr.sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.run   <= 1'b0;
            ctl_q.ratio <= 1'b0;
            ctl_q.sel   <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_q.run) |-> $stable(ctl_q.sel)); // R9

endmodule

// File: rtl/ep_src_mux.sv
module ep_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 6
) (
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic [SEL_W-1:0]   sel,
    output logic               ev_o
);

    always_comb begin
        ev_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                ev_o = src_vec[i];
            end
        end
    end

endmodule

// File: rtl/ep_event_core.sv
module ep_event_core #(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 6,
    parameter int FAST_LOG2 = 4,
    parameter int CNT_RST   = 2
) (
    input  logic             ev_clk,
    input  logic             arst_n,
    input  logic             ratio,
    output logic [CNT_W-1:0] gray_o,
    output logic             pre_o
);

    localparam logic [CNT_W-1:0] RST_BIN  = CNT_W'(CNT_RST);
    localparam logic [CNT_W-1:0] RST_GRAY = RST_BIN ^ (RST_BIN >> 1);
    localparam logic [1:0]       PRE_FULL = 2'd3;

    typedef struct packed {
        logic [1:0]       pre;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             out;
        logic [CNT_W-1:0] gray;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        hit  = ratio ? (&st_q.div) : (&st_q.div[FAST_LOG2-1:0]);
        st_d = st_q;
        if (st_q.pre != PRE_FULL) begin
            st_d.pre = 2'(st_q.pre + 2'd1);
        end else begin
            st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
        end
        st_d.div  = DIV_W'(st_q.div + 1'b1);
        st_d.out  = hit ? ~st_q.out : st_q.out;
        st_d.gray = st_d.cnt ^ (st_d.cnt >> 1);
    end

    always_ff @(posedge ev_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.pre  <= '0;
            st_q.cnt  <= RST_BIN;
            st_q.div  <= '0;
            st_q.out  <= 1'b0;
            st_q.gray <= RST_GRAY;
        end else begin
            st_q <= st_d;
        end
    end

    assign gray_o = st_q.gray;
    assign pre_o  = st_q.out;

    AST_CNT_FLOOR: assert property (@(posedge ev_clk) disable iff (!arst_n)
        (st_q.pre != PRE_FULL) |-> (st_q.cnt == RST_BIN)); // R3

    AST_CNT_STEP: assert property (@(posedge ev_clk) disable iff (!arst_n)
        (st_q.pre == PRE_FULL && $past(st_q.pre) == PRE_FULL)
            |-> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R4

endmodule

// File: rtl/ep_capture.sv
module ep_capture #(
    parameter int CNT_W   = 16,
    parameter int CNT_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_async,
    input  logic             cap_we,
    output logic [CNT_W-1:0] snap_o
);

    localparam logic [CNT_W-1:0] RST_BIN  = CNT_W'(CNT_RST);
    localparam logic [CNT_W-1:0] RST_GRAY = RST_BIN ^ (RST_BIN >> 1);

    typedef struct packed {
        logic [CNT_W-1:0] sync1;
        logic [CNT_W-1:0] sync2;
        logic [CNT_W-1:0] snap;
    } cap_st_t;

    cap_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = gray_async;
        st_d.sync2 = st_q.sync1;
        if (cap_we) begin
            st_d.snap = gray_to_bin(st_q.sync2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync1 <= RST_GRAY;
            st_q.sync2 <= RST_GRAY;
            st_q.snap  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o = st_q.snap;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_we |=> $stable(st_q.snap)); // R5

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
    import evt_prescaler_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_vec,
    input  logic                ctl_we,
    input  logic [EP_CTL_W-1:0] ctl_wdata,
    output logic [EP_CTL_W-1:0] ctl_rdata,
    input  logic                cap_we,
    output logic [EP_CNT_W-1:0] cap_rdata,
    output logic                pre_evt
);

    ep_ctl_t             ctl_q;
    logic                ev_clk;
    logic                core_rst_n;
    logic [EP_CNT_W-1:0] gray_live;

    ep_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl_o (ctl_q)
    );

    ep_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (EP_SEL_W)
    ) u_mux (
        .src_vec (src_vec),
        .sel     (ctl_q.sel),
        .ev_o    (ev_clk)
    );

    assign core_rst_n = rst_n & ctl_q.run;

    ep_event_core #(
        .CNT_W     (EP_CNT_W),
        .DIV_W     (EP_DIV_W),
        .FAST_LOG2 (EP_FAST_LOG2),
        .CNT_RST   (EP_CNT_RST)
    ) u_core (
        .ev_clk (ev_clk),
        .arst_n (core_rst_n),
        .ratio  (ctl_q.ratio),
        .gray_o (gray_live),
        .pre_o  (pre_evt)
    );

    ep_capture #(
        .CNT_W   (EP_CNT_W),
        .CNT_RST (EP_CNT_RST)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .gray_async (gray_live),
        .cap_we     (cap_we),
        .snap_o     (cap_rdata)
    );

    assign ctl_rdata = ctl_q;

    AST_PRE_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.run |-> !pre_evt); // R2

endmodule

// File: tb/evt_prescaler_test.sv
`timescale 1ns/1ps
module evt_prescaler_test;

    localparam int NSRC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] src_vec = '0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        cap_we = 1'b0;
    logic [15:0] cap_rdata;
    logic        pre_evt;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    evt_prescaler #(.NUM_SRC(NSRC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_vec   (src_vec),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .cap_we    (cap_we),
        .cap_rdata (cap_rdata),
        .pre_evt   (pre_evt)
    );

    function automatic logic [15:0] exp_count(input int n);
        if (n < 3) return 16'd2;
        return 16'(n - 1);
    endfunction

    function automatic logic exp_pre(input int n, input logic ratio);
        return ratio ? logic'((n >> 6) & 1) : logic'((n >> 4) & 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic run, input logic ratio, input logic [5:0] sel);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = {run, ratio, sel};
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic pulses(input int idx, input int n, input int half);
        for (int k = 0; k < n; k++) begin
            src_vec[idx] = 1'b1;
            #(half);
            src_vec[idx] = 1'b0;
            #(half);
        end
    endtask

    task automatic capture_check(input string tag, input logic [15:0] exp);
        repeat (4) @(negedge clk);
        cap_we = 1'b1;
        @(negedge clk);
        cap_we = 1'b0;
        check(tag, 32'(cap_rdata), 32'(exp));
    endtask

    task automatic start_run(input int sel, input logic ratio);
        write_ctl(1'b0, ratio, 6'(sel));
        write_ctl(1'b1, ratio, 6'(sel));
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctl_rdata", 32'(ctl_rdata), 32'h3F);
        check("R1 cap_rdata", 32'(cap_rdata), 32'h0);
        check("R1 pre_evt", 32'(pre_evt), 32'h0);

        // R2 held in reset: edges ignored
        write_ctl(1'b0, 1'b0, 6'd0);
        pulses(0, 40, 3);
        capture_check("R2 count held", 16'd2);
        check("R2 pre held low", 32'(pre_evt), 32'h0);

        // R3 small counts and floor
        for (int n = 0; n <= 5; n++) begin
            start_run(1, 1'b0);
            pulses(1, n, 3);
            capture_check($sformatf("R3 n=%0d", n), exp_count(n));
            write_ctl(1'b0, 1'b0, 6'd1);
        end

        // R5 snapshot holds without a write
        start_run(2, 1'b0);
        pulses(2, 10, 3);
        capture_check("R5 snapshot", exp_count(10));
        pulses(2, 7, 3);
        repeat (4) @(negedge clk);
        check("R5 hold without write", 32'(cap_rdata), 32'(exp_count(10)));
        capture_check("R5 recapture", exp_count(17));

        // R9 source locked while running
        write_ctl(1'b1, 1'b0, 6'd3);
        check("R9 sel locked", 32'(ctl_rdata), 32'h82);
        pulses(3, 5, 3);
        capture_check("R9 other input ignored", exp_count(17));
        write_ctl(1'b0, 1'b0, 6'd3);
        check("R9 ctl after stop", 32'(ctl_rdata), 32'h02);
        write_ctl(1'b0, 1'b1, 6'd3);
        check("R9 sel taken in reset", 32'(ctl_rdata), 32'h43);

        // R6 ratio 0 divider and R2 forced low
        start_run(0, 1'b0);
        pulses(0, 15, 3);
        repeat (2) @(negedge clk);
        check("R6 before 16th edge", 32'(pre_evt), 32'h0);
        pulses(0, 1, 3);
        repeat (2) @(negedge clk);
        check("R6 at 16th edge", 32'(pre_evt), 32'h1);
        write_ctl(1'b0, 1'b0, 6'd0);
        check("R2 pre forced low", 32'(pre_evt), 32'h0);
        capture_check("R2 count back to 2", 16'd2);

        // R7 ratio 1 divider
        start_run(0, 1'b1);
        pulses(0, 63, 3);
        repeat (2) @(negedge clk);
        check("R7 before 64th edge", 32'(pre_evt), 32'h0);
        pulses(0, 1, 3);
        repeat (2) @(negedge clk);
        check("R7 at 64th edge", 32'(pre_evt), 32'h1);
        write_ctl(1'b0, 1'b1, 6'd0);

        // R8 out-of-range source
        write_ctl(1'b0, 1'b0, 6'd63);
        write_ctl(1'b1, 1'b0, 6'd63);
        for (int s = 0; s < NSRC; s++) pulses(s, 20, 3);
        capture_check("R8 no source counted", 16'd2);
        check("R8 pre low", 32'(pre_evt), 32'h0);
        write_ctl(1'b0, 1'b0, 6'd63);

        // R3 R6 R7 R8 random runs
        for (int it = 0; it < 10; it++) begin
            int   s;
            int   n;
            logic r;
            s = int'($urandom % NSRC);
            n = int'($urandom % 300);
            r = logic'($urandom % 2);
            start_run(s, r);
            pulses(s, n, 2 + int'($urandom % 3));
            capture_check($sformatf("R3 R8 random src=%0d n=%0d", s, n), exp_count(n));
            check($sformatf("R6 R7 random ratio=%0d n=%0d", r, n), 32'(pre_evt), 32'(exp_pre(n, r)));
            write_ctl(1'b0, r, 6'(s));
        end

        // R4 R10 wrap with sub-cycle pulses
        start_run(0, 1'b0);
        pulses(0, 65540, 1);
        capture_check("R4 R10 wrap count", exp_count(65540));
        check("R6 R10 pre after wrap", 32'(pre_evt), 32'(exp_pre(65540, 1'b0)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule